// File: doc/BRIEF.md
# Programmable Symmetric Function Evaluator

This block computes a symmetric Boolean function of `N` input bits. Such a function depends only on how many of the inputs are set. The block counts the set inputs and then uses that count as an index into a run-time mask of `N+1` bits, one bit for each possible count from 0 to `N`. The function is true when the mask bit for the current count is set. A mask of `N+1` bits can express every one of the 2^(N+1) symmetric functions of `N` variables.

A second mask is looked up from the same shared count. A two-bit operation select then chooses the result:

- the first function alone,
- the union of the two functions,
- their intersection,
- the complement of the first function.

The result is available combinationally. It is also available from a registered stage that updates on the rising clock edge.

Top module: `symfn_eval`

## Requirements
- R1: The internal count equals the number of set bits of `in_bits`. With `op_sel` = 2'b00, `y_now` equals bit `count` of `mask_a`, for every input pattern.
- R2: An all-zero `mask_a` with `op_sel` = 2'b00 gives `y_now` = 0 for every input. An all-ones `mask_a` gives `y_now` = 1 for every input.
- R3: With `op_sel` = 2'b01, `y_now` equals `mask_a[count] | mask_b[count]`, which is the union of the two masks.
- R4: With `op_sel` = 2'b10, `y_now` equals `mask_a[count] & mask_b[count]`, which is the intersection of the two masks.
- R5: With `op_sel` = 2'b11, `y_now` equals `~mask_a[count]`. `mask_b` has no effect on `y_now` in this mode, nor in mode 2'b00.
- R6: The odd-count mask (bits 1, 3 and 5 set, 7'h2A for N=6) gives odd parity of the inputs. The even-count mask (7'h55) gives even parity. A mask with bits 4, 5 and 6 set gives "at least four inputs set".
- R7: When `rst_n` is high at a rising edge of `clk`, `y_q` takes the value that `y_now` had just before that edge.
- R8: When `rst_n` is low at a rising edge of `clk`, `y_q` becomes 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered output |
| rst_n | input | 1 | Synchronous reset, active low |
| in_bits | input | N | Input bits that are counted |
| mask_a | input | N+1 | Membership mask over counts 0..N for the first function |
| mask_b | input | N+1 | Membership mask over counts 0..N for the second function |
| op_sel | input | 2 | Operation: 00 = A, 01 = A or B, 10 = A and B, 11 = not A |
| y_now | output | 1 | Combinational result |
| y_q | output | 1 | Registered result |

## Verification
The hardest case to reach is a difference at the ends of the count range. Counts 0 and `N` each come from only one input pattern, so random input patterns seldom reach them, and a wrong mask bit at either end would rarely show up. For this reason the stimulus walks every one of the 2^N input patterns for each mask pair and each operation, using seeded random masks mixed with fixed masks for the all-zero, all-ones, parity and threshold cases. Reset is applied while the combinational result is 1, so that clearing `y_q` can be seen at the output.

// File: rtl/symfn_pkg.sv
// Shared types for the symmetric function evaluator.
// Assumes op_sel is a two-bit field with the encoding below.
package symfn_pkg;
    typedef enum logic [1:0] {
        OP_A     = 2'b00,
        OP_OR    = 2'b01,
        OP_AND   = 2'b10,
        OP_NOT_A = 2'b11
    } symfn_op_e;
endpackage

// File: rtl/symfn_popcount.sv
// Counts the set bits of a vector using a combinational adder chain.
// Assumes CW is wide enough to hold the value N.
module symfn_popcount #(
    parameter int N  = 6,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits_i,
    output logic [CW-1:0] count_o
);
    // Sum the input bits one at a time.
    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) begin
            count_o = count_o + CW'(bits_i[i]);
        end
    end
endmodule

// File: rtl/symfn_lookup.sv
// Selects the mask bit for the current count.
// Decodes the count to one-hot and ANDs the result with the mask.
// Assumes count_i never goes above N.
module symfn_lookup #(
    parameter int N  = 6,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [CW-1:0] count_i,
    input  logic [N:0]    mask_i,
    output logic          hit_o
);
    logic [N:0] onehot;

    for (genvar k = 0; k <= N; k++) begin : g_dec
        // Decode one count value.
        assign onehot[k] = (count_i == CW'(k));
    end

    // Reduce the masked one-hot vector to a single bit.
    assign hit_o = |(onehot & mask_i);
endmodule

// File: rtl/symfn_combine.sv
// Combines the two looked-up functions according to the operation select.
module symfn_combine
    import symfn_pkg::*;
(
    input  logic [1:0] op_i,
    input  logic       a_i,
    input  logic       b_i,
    output logic       y_o
);
    // Pick the set operation.
    always_comb begin
        unique case (symfn_op_e'(op_i))
            OP_A:     y_o = a_i;
            OP_OR:    y_o = a_i | b_i;
            OP_AND:   y_o = a_i & b_i;
            OP_NOT_A: y_o = ~a_i;
            default:  y_o = a_i;
        endcase
    end
endmodule

// File: rtl/symfn_eval.sv
// Top level of the symmetric function evaluator.
// One shared count drives two mask lookups. The lookups are then combined,
// and the result is also captured in a register that has a synchronous
// active-low reset.
module symfn_eval #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_bits,
    input  logic [N:0]   mask_a,
    input  logic [N:0]   mask_b,
    input  logic [1:0]   op_sel,
    output logic         y_now,
    output logic         y_q
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt_w;
    logic          hit_a;
    logic          hit_b;

    symfn_popcount #(.N(N), .CW(CW)) u_cnt (
        .bits_i (in_bits),
        .count_o(cnt_w)
    );

    symfn_lookup #(.N(N), .CW(CW)) u_look_a (
        .count_i(cnt_w),
        .mask_i (mask_a),
        .hit_o  (hit_a)
    );

    symfn_lookup #(.N(N), .CW(CW)) u_look_b (
        .count_i(cnt_w),
        .mask_i (mask_b),
        .hit_o  (hit_b)
    );

    symfn_combine u_comb (
        .op_i(op_sel),
        .a_i (hit_a),
        .b_i (hit_b),
        .y_o (y_now)
    );

    // Register the combined result.
    always_ff @(posedge clk) begin
        if (!rst_n) y_q <= 1'b0;
        else        y_q <= y_now;
    end
endmodule

// File: rtl/symfn_eval_chk.sv
// Property checker for symfn_eval. It is attached to the top module by bind.
module symfn_eval_chk #(
    parameter int N  = 6,
    parameter int CW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  in_bits,
    input logic [N:0]    mask_a,
    input logic [1:0]    op_sel,
    input logic [CW-1:0] cnt,
    input logic          hit_a,
    input logic          hit_b,
    input logic          y_now,
    input logic          y_q
);
    logic primed = 1'b0;

    // Mark that at least one edge has passed.
    always_ff @(posedge clk) primed <= 1'b1;

    // R1
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt == CW'($countones(in_bits)));

    // R2
    zero_mask_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_a == '0 && op_sel == 2'b00) |-> !y_now);

    // R3
    union_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b01) |-> (y_now == (hit_a | hit_b)));

    // R4
    intersect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b10) |-> (y_now == (hit_a & hit_b)));

    // R5
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b11) |-> (y_now != hit_a));

    // R7
    reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(rst_n)) |-> (y_q == $past(y_now)));
endmodule

bind symfn_eval symfn_eval_chk #(.N(N), .CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_bits(in_bits),
    .mask_a (mask_a),
    .op_sel (op_sel),
    .cnt    (cnt_w),
    .hit_a  (hit_a),
    .hit_b  (hit_b),
    .y_now  (y_now),
    .y_q    (y_q)
);

// File: tb/symfn_eval_test.sv
// Self-checking bench for symfn_eval. Every input pattern is applied for
// fixed and seeded random masks, and the results are compared with a
// reference model written as a bench function.
module symfn_eval_test;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] in_bits = '0;
    logic [N:0]   mask_a = '0;
    logic [N:0]   mask_b = '0;
    logic [1:0]   op_sel = 2'b00;
    logic         y_now;
    logic         y_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    symfn_eval #(.N(N)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_bits(in_bits),
        .mask_a (mask_a),
        .mask_b (mask_b),
        .op_sel (op_sel),
        .y_now  (y_now),
        .y_q    (y_q)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Reference model computed from the requirements.
    function automatic logic ref_y(logic [N-1:0] v, logic [N:0] ma,
                                   logic [N:0] mb, logic [1:0] op);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        case (op)
            2'b00:   return ma[c];
            2'b01:   return ma[c] | mb[c];
            2'b10:   return ma[c] & mb[c];
            default: return ~ma[c];
        endcase
    endfunction

    // Compare one value and report a mismatch.
    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (in=%b ma=%b mb=%b op=%b)",
                     tag, act, exp, in_bits, mask_a, mask_b, op_sel);
        end
    endtask

    // Apply one input pattern, check y_now, then check y_q after the edge.
    task automatic apply(string tag, logic [N-1:0] v);
        logic e;
        @(negedge clk);
        in_bits = v;
        #1;
        e = ref_y(v, mask_a, mask_b, op_sel);
        check(tag, y_now, e);
        @(posedge clk);
        #1;
        check("R7", y_q, e);
    endtask

    // Walk every input pattern for one mask pair and one operation.
    task automatic sweep(string tag, logic [N:0] ma, logic [N:0] mb, logic [1:0] op);
        mask_a = ma;
        mask_b = mb;
        op_sel = op;
        for (int p = 0; p < (1 << N); p++) apply(tag, N'(p));
    endtask

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));

        // Reset state (R8).
        repeat (2) @(posedge clk);
        #1;
        check("R8", y_q, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: one-hot masks pick each single count.
        for (int k = 0; k <= N; k++) sweep("R1", (N+1)'(1) << k, '0, 2'b00);
        // R2: constant masks.
        sweep("R2", '0, '1, 2'b00);
        sweep("R2", '1, '0, 2'b00);
        // R6: parity and threshold masks.
        sweep("R6", 7'h2A, '0, 2'b00);
        sweep("R6", 7'h55, '0, 2'b00);
        sweep("R6", 7'h70, '0, 2'b00);
        // R5: complement of the odd mask, with mask_b set to all ones.
        sweep("R5", 7'h2A, '1, 2'b11);
        // R5: mask_b has no effect in mode 00.
        sweep("R5", 7'h13, 7'h6C, 2'b00);
        // R3, R4: union and intersection with seeded random masks.
        for (int r = 0; r < 6; r++) begin
            logic [N:0] ra, rb;
            ra = (N+1)'($urandom());
            rb = (N+1)'($urandom());
            sweep("R1", ra, rb, 2'b00);
            sweep("R3", ra, rb, 2'b01);
            sweep("R4", ra, rb, 2'b10);
            sweep("R5", ra, rb, 2'b11);
        end

        // R8: reset while the combinational result is 1.
        mask_a = '1;
        op_sel = 2'b00;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R2", y_now, 1'b1);
        @(posedge clk);
        #1;
        check("R8", y_q, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R7", y_q, 1'b1);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule